// File: doc/BRIEF.md
# I2C Slave Front End for a Byte-Wide Zero-Delay Memory

This block lets a two-wire bus master read and write a byte-wide memory of 16K locations. It samples SCL and SDA with the system clock and finds START and STOP conditions in those samples. It answers one 7-bit slave address, which is a fixed device-type nibble followed by three strap inputs. A write transaction loads a 14-bit pointer from two address bytes and then stores any number of data bytes. A read transaction streams bytes out, starting at the pointer, for as long as the master keeps acknowledging.

Each data byte is committed to the array at the end of its eighth bit, before the acknowledge slot. The master never has to poll for a busy state. After every byte the pointer advances by one, wraps from 3FFFh to 0000h, and keeps its value between transactions. A START or STOP seen at any point aborts the transaction in progress.

A write-protect input makes the block refuse data bytes. A master code of the form 00001xxx switches on a high-speed flag, and the next STOP clears it. SDA leaves the block as an open-drain pull-down enable. The array sits outside the block and is reached through a synchronous RAM port with one cycle of read latency.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset `sda_oe`, `hs_mode` and `mem_we` are 0, and the pointer shown on `mem_addr` is 0. A read issued straight after reset therefore returns location 0.
- R2: An address byte whose bits 7..1 equal {1010b, `strap_i`} is acknowledged. Bit 0 selects the direction: 1 for read, 0 for write. Any other address byte is not acknowledged, and the block ignores the bus until the next START.
- R3: In a write transaction, the first byte after the address is the pointer high byte and the second is the low byte. Only bits 5..0 of the high byte are used, so the pointer takes {high[5:0], low}.
- R4: Each acknowledged data byte of a write is stored at the pointer with a single `mem_we` pulse. The pointer then increases by one, and any number of bytes may follow in sequence.
- R5: The pointer wraps from 3FFFh to 0000h, for reads and for writes.
- R6: A read returns bytes MSB first, starting at the pointer. A master ACK makes the block send the next location. A master NACK ends the read and releases SDA.
- R7: A repeated START after the address bytes of a write, followed by a read address byte, reads from the location just loaded.
- R8: A START or STOP that arrives before the eighth bit of a data byte leaves the memory unchanged.
- R9: While `wp_i` is 1, data bytes are not acknowledged, nothing is written and the pointer does not change.
- R10: An address byte of the form 00001xxx is not acknowledged and sets `hs_mode`. `hs_mode` stays set through later transactions and is cleared by the next STOP.
- R11: The pointer keeps its value between transactions, so a read without an address phase continues from the location after the last one accessed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Board strap compared with address bits 3..1 |
| wp_i | input | 1 | 1 refuses all data writes |
| hs_mode | output | 1 | High-speed flag set by the master code |
| mem_addr | output | 14 | Array address, equal to the pointer |
| mem_we | output | 1 | One-cycle array write strobe |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, one cycle after `mem_addr` |

## Verification
A table of addresses is written one byte at a time and read back with a random read. Setting the two unused high-byte bits in each entry separates a 14-bit pointer load from a 16-bit one. Multi-byte writes and reads, at mid range and across 3FFFh, show whether the pointer advances once per byte and wraps, rather than skipping or sticking. Wrong address bytes, a master code, a protected write and a write cut short by STOP each have a correct outcome that differs from an accepted write. Looking at the ACK bit, `mem_addr` and the stored data after each of these shows that refused traffic leaves no trace.

// File: rtl/i2c_mem_slave.sv
`timescale 1ns/1ps
module i2c_mem_slave #(
  parameter int          PTR_W    = 14,
  parameter logic [3:0]  DEV_TYPE = 4'b1010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [2:0]       strap_i,
  input  logic             wp_i,
  output logic             hs_mode,
  output logic [PTR_W-1:0] mem_addr,
  output logic             mem_we,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata
);
  localparam int HI_W = PTR_W - 8;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_WR, S_RD} st_t;

  logic [2:0]       scl_q, sda_q;
  st_t              st;
  logic [3:0]       bitcnt;
  logic [7:0]       sh;
  logic             rw;
  logic [HI_W-1:0]  ahi;
  logic [PTR_W-1:0] ptr;

  logic scl_rise, scl_fall, start_evt, stop_evt, dev_hit, mcode;
  assign scl_rise  = scl_q[1] & ~scl_q[2];
  assign scl_fall  = ~scl_q[1] & scl_q[2];
  assign start_evt = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_evt  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  assign dev_hit   = (sh[7:1] == {DEV_TYPE, strap_i});
  assign mcode     = (sh[7:3] == 5'b00001);
  assign mem_addr  = ptr;
  assign mem_wdata = sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      bitcnt  <= '0;
      sh      <= '0;
      rw      <= 1'b0;
      ahi     <= '0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
      hs_mode <= 1'b0;
      mem_we  <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (mem_we) ptr <= ptr + PTR_W'(1);
      if (start_evt) begin
        st     <= S_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        st      <= S_IDLE;
        sda_oe  <= 1'b0;
        hs_mode <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          sh <= {sh[6:0], sda_q[1]};
          if (bitcnt < 4'd8) bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            bitcnt <= 4'd9;
            case (st)
              S_DEV: if (dev_hit) begin
                       sda_oe <= 1'b1;
                       rw     <= sh[0];
                     end else begin
                       st <= S_IDLE;
                       if (mcode) hs_mode <= 1'b1;
                     end
              S_AHI: begin sda_oe <= 1'b1; ahi <= sh[HI_W-1:0]; end
              S_ALO: begin sda_oe <= 1'b1; ptr <= {ahi, sh}; end
              S_WR:  if (!wp_i) begin
                       sda_oe <= 1'b1;
                       mem_we <= 1'b1;
                     end else st <= S_IDLE;
              S_RD:  begin sda_oe <= 1'b0; ptr <= ptr + PTR_W'(1); end
              default: ;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            sda_oe <= 1'b0;
            case (st)
              S_DEV: if (rw) begin
                       st     <= S_RD;
                       sh     <= mem_rdata;
                       sda_oe <= ~mem_rdata[7];
                     end else st <= S_AHI;
              S_AHI: st <= S_ALO;
              S_ALO: st <= S_WR;
              S_RD:  if (!sh[0]) begin
                       sh     <= mem_rdata;
                       sda_oe <= ~mem_rdata[7];
                     end else st <= S_IDLE;
              default: ;
            endcase
          end else if (st == S_RD) begin
            sda_oe <= ~sh[7];
          end
        end
      end
    end
  end

  assert_we_blocked_by_wp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !$past(wp_i));
  assert_ptr_step_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_addr == $past(mem_addr) + PTR_W'(1)) && !mem_we);
  assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (mem_addr == {PTR_W{1'b1}})) |=> (mem_addr == '0));
  assert_stop_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !hs_mode && !sda_oe);
  assert_idle_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);
  assert_start_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe && !mem_we);
endmodule

// File: tb/i2c_mem_slave_test.sv
`timescale 1ns/1ps
module i2c_mem_slave_test;
  localparam int CLK_NS = 10;
  localparam int Q      = 100;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEVW  = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEVR  = {4'b1010, STRAP, 1'b1};
  localparam int NV = 6;
  localparam logic [21:0] VEC [NV] = '{
    {14'h0010, 8'h5A}, {14'h0123, 8'hC3}, {14'h0255, 8'h00},
    {14'h02AA, 8'hFF}, {14'h1F0F, 8'h81}, {14'h3C41, 8'h7E}};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, hs_mode, mem_we;
  logic [13:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] mem [1024];
  logic sda_ln;
  int checks = 0, errors = 0;
  bit done = 0;

  assign sda_ln = sda_m & ~sda_oe;
  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:0]];
  end

  i2c_mem_slave uut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_ln),
    .sda_oe(sda_oe), .strap_i(STRAP), .wp_i(wp), .hs_mode(hs_mode),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata));

  function automatic logic [7:0] init_val(input logic [13:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic i_start();
    sda_m = 1'b1; #Q scl = 1'b1; #Q sda_m = 1'b0; #Q scl = 1'b0; #Q;
  endtask

  task automatic i_stop();
    sda_m = 1'b0; #Q scl = 1'b1; #Q sda_m = 1'b1; #Q;
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #Q scl = 1'b1; #(2*Q) scl = 1'b0; #Q;
    end
    sda_m = 1'b1; #Q scl = 1'b1; #Q ack = ~sda_ln; #Q scl = 1'b0; #Q;
  endtask

  task automatic recv(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #Q scl = 1'b1; #Q b[i] = sda_ln; #Q scl = 1'b0; #Q;
    end
    sda_m = ~mack; #Q scl = 1'b1; #(2*Q) scl = 1'b0; #Q; sda_m = 1'b1;
  endtask

  task automatic load_ptr(input logic [13:0] a, input logic [1:0] junk, input string tag);
    bit ack;
    i_start();
    send(DEVW, ack);               chk({tag, " R2 dev ack"}, ack, 1);
    send({junk, a[13:8]}, ack);    chk({tag, " R3 hi ack"}, ack, 1);
    send(a[7:0], ack);             chk({tag, " R3 lo ack"}, ack, 1);
  endtask

  task automatic read_at(input logic [13:0] a, output logic [7:0] d);
    bit ack;
    load_ptr(a, 2'b00, "R7");
    i_start();
    send(DEVR, ack); chk("R7 read dev ack", ack, 1);
    recv(1'b0, d);
    i_stop();
  endtask

  initial begin
    #(200000 * CLK_NS);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    for (int i = 0; i < 1024; i++) mem[i] = init_val(14'(i));
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    #(Q - 1);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 hs_mode", hs_mode, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 pointer", mem_addr, 0);
    i_start(); send(DEVR, ack); chk("R1 dev ack", ack, 1);
    recv(1'b0, d); i_stop();
    chk("R1 read at 0", d, init_val(14'h0));
    chk("R6 pointer after read", mem_addr, 1);

    for (int v = 0; v < NV; v++) begin
      logic [13:0] a;
      logic [7:0] wd;
      a  = VEC[v][21:8];
      wd = VEC[v][7:0];
      load_ptr(a, 2'b11, "R3");
      send(wd, ack); chk("R4 data ack", ack, 1);
      i_stop();
      chk("R3 R4 pointer after write", mem_addr, 32'(a) + 1);
      read_at(a, d);
      chk("R4 R7 readback", d, wd);
    end

    load_ptr(14'h0200, 2'b00, "R4");
    send(8'h01, ack); send(8'h02, ack); send(8'h03, ack);
    chk("R4 third byte ack", ack, 1);
    i_stop();
    load_ptr(14'h0200, 2'b00, "R6");
    i_start(); send(DEVR, ack);
    recv(1'b1, d); chk("R6 seq byte0", d, 8'h01);
    recv(1'b1, d); chk("R6 seq byte1", d, 8'h02);
    recv(1'b0, d); chk("R6 seq byte2", d, 8'h03);
    chk("R6 released after nack", sda_oe, 0);
    i_stop();
    i_start(); send(DEVR, ack); recv(1'b0, d); i_stop();
    chk("R11 current address read", d, init_val(14'h0203));

    load_ptr(14'h3FFF, 2'b00, "R5");
    send(8'h11, ack); send(8'h22, ack); i_stop();
    chk("R5 pointer wrapped", mem_addr, 14'h0001);
    load_ptr(14'h3FFF, 2'b00, "R5");
    i_start(); send(DEVR, ack);
    recv(1'b1, d); chk("R5 read 3FFF", d, 8'h11);
    recv(1'b0, d); chk("R5 read 0000", d, 8'h22);
    i_stop();

    i_start(); send({4'b1010, 3'b011, 1'b0}, ack); chk("R2 strap mismatch nack", ack, 0);
    send(8'h00, ack); chk("R2 ignored until start", ack, 0);
    i_stop();
    i_start(); send({4'b1011, STRAP, 1'b0}, ack); chk("R2 type mismatch nack", ack, 0);
    i_stop();

    load_ptr(14'h0050, 2'b00, "R8");
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b0; #Q scl = 1'b1; #(2*Q) scl = 1'b0; #Q;
    end
    i_stop();
    read_at(14'h0050, d);
    chk("R8 aborted write left memory", d, init_val(14'h0050));

    wp = 1'b1;
    load_ptr(14'h0100, 2'b00, "R9");
    send(8'h77, ack); chk("R9 protected data nack", ack, 0);
    i_stop();
    chk("R9 pointer held", mem_addr, 14'h0100);
    wp = 1'b0;
    read_at(14'h0100, d);
    chk("R9 memory unchanged", d, init_val(14'h0100));

    i_start(); send(8'h09, ack); chk("R10 master code nack", ack, 0);
    chk("R10 hs_mode set", hs_mode, 1);
    load_ptr(14'h0300, 2'b00, "R10");
    send(8'h3C, ack); chk("R10 write in hs", ack, 1);
    chk("R10 hs_mode held", hs_mode, 1);
    i_stop();
    chk("R10 hs_mode cleared by stop", hs_mode, 0);
    read_at(14'h0300, d);
    chk("R10 hs write stored", d, 8'h3C);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule